// File: doc/BRIEF.md
# Configuration Space Address/Data Port Decoder

This block sits on a host I/O bus and gives software indirect access to the configuration space of bus functions through two I/O locations. A full 32-bit write to the address port selects a target. That value holds an enable flag, a bus number, a device/function number and a dword register index. Accesses to a four-byte data window then become configuration requests aimed at the selected function.

Each data-window access may be one, two or four bytes wide. The block forms a byte offset inside the target's configuration space from the latched dword index and the low address bits of the access. It also produces byte enables and places write data in the matching byte lanes, little-endian. On reads it takes the addressed bytes from the returned dword and right-justifies them. An outside lookup reports whether the selected bus/devfn slot holds a function. When it does not, or when the enable flag is clear, writes are dropped and reads return all ones at the access width.

Top module: `cfg_portdec`

## Requirements
- R1: The address register resets to zero. A 4-byte write at the address port (0xCF8, low address bits 00) stores all 32 bits, and a 4-byte read there returns them unchanged one cycle later.
- R2: A 1- or 2-byte access anywhere in 0xCF8..0xCFB leaves the address register unchanged and produces no read response.
- R3: `cfg_bus` always shows address register bits 23:16, and `cfg_devfn` always shows bits 15:8.
- R4: During a request, `cfg_offset` equals (address register AND 0xFC) OR (data-port address AND 3).
- R5: Byte enables are 4'b0001, 4'b0011 or 4'b1111 for `io_size` 0, 1 or 2 (1, 2 or 4 bytes), shifted left by the data-port lane (address bits 1:0).
- R6: For a write request, `cfg_wdata` holds the low access-width bytes of `io_wdata`, shifted up by 8 times the lane. All bytes outside the enabled lanes are zero.
- R7: A data-port read of a present function with address bit 31 set returns, one cycle later with `io_rvalid` high, the enabled bytes of `cfg_rdata` shifted down to bit 0. All upper bits are zero.
- R8: `cfg_req` is high only for a data-port access while address bit 31 is set and `cfg_present` is high. Otherwise a write is silently dropped, and a read returns all ones in the low access-width bytes with zeros above.
- R9: A data-port access that would cross the dword (2 bytes at lane 3, or 4 bytes at a lane other than 0), or that uses `io_size` 3, is ignored: there is no request and no read response.
- R10: Accesses to I/O addresses outside 0xCF8..0xCFF produce no request and no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host I/O access this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | Host I/O byte address |
| io_size | input | 2 | 0 = byte, 1 = word, 2 = dword |
| io_wdata | input | 32 | Right-justified host write data |
| io_rvalid | output | 1 | Read response valid (one cycle after the read) |
| io_rdata | output | 32 | Right-justified read data |
| cfg_req | output | 1 | Configuration request to the selected function |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device (7:3) and function (2:0) |
| cfg_offset | output | 8 | Configuration byte offset |
| cfg_be | output | 4 | Byte enables of the configuration dword |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_present | input | 1 | A function exists at cfg_bus/cfg_devfn |
| cfg_rdata | input | 32 | Lane-aligned dword read from the function |

## Verification
A corrupted address register appears at once on `cfg_bus` and `cfg_devfn`. It also appears one cycle after the next dword read of the address port, so the bench reads the register back after every change. A wrong lane or offset shows up in the same cycle as a misplaced byte enable or write byte. On reads it shows up one cycle later as the wrong bytes in `io_rdata`. A mistake in the miss logic appears as a request leaking to an absent slot, or as read data other than all ones.

// File: rtl/cfg_portdec.sv
module cfg_portdec #(
  parameter int             IO_AW     = 16,
  parameter logic [15:0]    ADDR_PORT = 16'hCF8,
  parameter logic [15:0]    DATA_PORT = 16'hCFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic             io_write,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [1:0]       io_size,
  input  logic [31:0]      io_wdata,
  output logic             io_rvalid,
  output logic [31:0]      io_rdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [7:0]       cfg_devfn,
  output logic [7:0]       cfg_offset,
  output logic [3:0]       cfg_be,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_present,
  input  logic [31:0]      cfg_rdata
);

  logic [31:0] addr_q;
  logic [1:0]  lane;
  logic        at_addr, at_data, size_ok;
  logic        addr_acc, data_acc;
  logic [31:0] wmask;
  logic [3:0]  be_base;
  logic [4:0]  shamt;
  logic [31:0] rd_val;

  assign lane    = io_addr[1:0];
  assign shamt   = {lane, 3'b000};
  assign at_addr = (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
  assign at_data = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

  always_comb begin
    case (io_size)
      2'd0:    begin size_ok = 1'b1;          wmask = 32'h0000_00FF; be_base = 4'b0001; end
      2'd1:    begin size_ok = (lane != 2'd3); wmask = 32'h0000_FFFF; be_base = 4'b0011; end
      2'd2:    begin size_ok = (lane == 2'd0); wmask = 32'hFFFF_FFFF; be_base = 4'b1111; end
      default: begin size_ok = 1'b0;          wmask = 32'h0000_0000; be_base = 4'b0000; end
    endcase
  end

  assign addr_acc = io_valid && at_addr && (io_size == 2'd2) && (lane == 2'd0);
  assign data_acc = io_valid && at_data && size_ok;

  assign cfg_bus    = addr_q[23:16];
  assign cfg_devfn  = addr_q[15:8];
  assign cfg_offset = {addr_q[7:2], lane};
  assign cfg_req    = data_acc && addr_q[31] && cfg_present;
  assign cfg_we     = io_write;
  assign cfg_be     = be_base << lane;
  assign cfg_wdata  = (io_wdata & wmask) << shamt;

  always_comb begin
    if (addr_acc)     rd_val = addr_q;
    else if (cfg_req) rd_val = (cfg_rdata >> shamt) & wmask;
    else              rd_val = wmask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      if (addr_acc && io_write) addr_q <= io_wdata;
      io_rvalid <= (addr_acc || data_acc) && !io_write;
      if ((addr_acc || data_acc) && !io_write) io_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/cfg_portdec_chk.sv
module cfg_portdec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_valid,
  input logic        io_write,
  input logic        io_rvalid,
  input logic        cfg_req,
  input logic        cfg_present,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] addr_q
);

  logic [31:0] be_bits;
  assign be_bits = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};

  assert_req_needs_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_present && addr_q[31]));

  assert_be_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 || $countones(cfg_be) == 4));

  assert_wdata_in_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && io_write) |-> ((cfg_wdata & ~be_bits) == 32'h0));

  assert_resp_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_valid && !io_write));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_valid && io_write) |=> $stable(addr_q));

endmodule

bind cfg_portdec cfg_portdec_chk chk (
  .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
  .io_rvalid(io_rvalid), .cfg_req(cfg_req), .cfg_present(cfg_present),
  .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .addr_q(addr_q)
);

// File: tb/cfg_portdec_test.sv
module cfg_portdec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_rvalid, cfg_req, cfg_we, cfg_present;
  logic [31:0] io_rdata, cfg_wdata, cfg_rdata;
  logic [7:0]  cfg_bus, cfg_devfn, cfg_offset;
  logic [3:0]  cfg_be;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] model(logic [7:0] b, logic [7:0] df, logic [5:0] dw);
    return {df, b ^ 8'h3C, dw, 2'b01, 8'h96 ^ df};
  endfunction

  assign cfg_present = !cfg_bus[0] && !cfg_devfn[3];
  assign cfg_rdata   = model(cfg_bus, cfg_devfn, cfg_offset[7:2]);

  cfg_portdec uut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_offset(cfg_offset),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_present(cfg_present),
    .cfg_rdata(cfg_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic        s_req, s_we, s_rv;
  logic [7:0]  s_off;
  logic [3:0]  s_be;
  logic [31:0] s_wd, s_rd;

  task automatic io_op(logic wr, logic [15:0] a, logic [1:0] sz, logic [31:0] wd);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
    #5;
    s_req = cfg_req; s_we = cfg_we; s_off = cfg_offset; s_be = cfg_be; s_wd = cfg_wdata;
    @(posedge clk);
    #5;
    s_rv = io_rvalid; s_rd = io_rdata;
    io_valid = 1'b0;
  endtask

  function automatic logic [31:0] wmask(logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R8 reset no request", {31'b0, cfg_req}, 32'h0);
    chk("R1 reset rvalid", {31'b0, io_rvalid}, 32'h0);
    rst_n = 1'b1;

    io_op(0, 16'hCF8, 2, 0);
    chk("R1 reset readback valid", {31'b0, s_rv}, 1);
    chk("R1 reset value", s_rd, 32'h0);

    io_op(1, 16'hCF8, 2, 32'h7FA5_C303);
    io_op(0, 16'hCF8, 2, 0);
    chk("R1 raw readback", s_rd, 32'h7FA5_C303);
    chk("R3 bus field", {24'b0, cfg_bus}, 32'hA5);
    chk("R3 devfn field", {24'b0, cfg_devfn}, 32'hC3);

    io_op(1, 16'hCF9, 0, 32'h55);
    io_op(1, 16'hCFA, 1, 32'h1234);
    io_op(0, 16'hCF8, 2, 0);
    chk("R2 narrow write ignored", s_rd, 32'h7FA5_C303);
    io_op(0, 16'hCF8, 1, 0);
    chk("R2 narrow read no response", {31'b0, s_rv}, 0);
    io_op(0, 16'hCFB, 0, 0);
    chk("R2 byte read no response", {31'b0, s_rv}, 0);

    io_op(1, 16'hCF8, 2, 32'h0000_0010);
    io_op(0, 16'hCFC, 2, 0);
    chk("R8 disabled no request", {31'b0, s_req}, 0);
    chk("R8 disabled dword", s_rd, 32'hFFFF_FFFF);
    io_op(0, 16'hCFE, 0, 0);
    chk("R8 disabled byte", s_rd, 32'h0000_00FF);
    io_op(0, 16'hCFE, 1, 0);
    chk("R8 disabled word", s_rd, 32'h0000_FFFF);
    io_op(1, 16'hCFC, 2, 32'h1);
    chk("R8 disabled write dropped", {31'b0, s_req}, 0);

    for (int bi = 0; bi < 3; bi++) begin
      for (int di = 0; di < 4; di++) begin
        for (int wi = 0; wi < 4; wi++) begin
          logic [7:0] b, df;
          logic [5:0] dw;
          logic pres;
          b  = (bi == 0) ? 8'h00 : (bi == 1) ? 8'h01 : 8'hF2;
          df = (di == 0) ? 8'h00 : (di == 1) ? 8'h08 : (di == 2) ? 8'h17 : 8'hF8;
          dw = (wi == 0) ? 6'd0 : (wi == 1) ? 6'd1 : (wi == 2) ? 6'd15 : 6'd63;
          pres = !b[0] && !df[3];
          io_op(1, 16'hCF8, 2, {1'b1, 7'b0, b, df, dw, 2'b00});
          chk("R3 bus follows address", {24'b0, cfg_bus}, {24'b0, b});
          chk("R3 devfn follows address", {24'b0, cfg_devfn}, {24'b0, df});
          for (int ln = 0; ln < 4; ln++) begin
            for (int sz = 0; sz < 3; sz++) begin
              logic [31:0] m, wd;
              logic [3:0] be;
              if ((sz == 1 && ln == 3) || (sz == 2 && ln != 0)) continue;
              m  = wmask(sz[1:0]);
              be = ((sz == 0) ? 4'b0001 : (sz == 1) ? 4'b0011 : 4'b1111) << ln;
              io_op(0, 16'hCFC + 16'(ln), sz[1:0], 0);
              chk("R8 request iff present", {31'b0, s_req}, {31'b0, pres});
              chk("R7 read response valid", {31'b0, s_rv}, 1);
              if (pres) begin
                chk("R4 offset", {24'b0, s_off}, {24'b0, dw, 2'(ln)});
                chk("R5 byte enables", {28'b0, s_be}, {28'b0, be});
                chk("R7 read data", s_rd, (model(b, df, dw) >> (8 * ln)) & m);
              end else begin
                chk("R8 miss all ones", s_rd, m);
              end
              wd = 32'hC0DE_0000 ^ {dw, 2'(ln), 8'(sz), df, b};
              io_op(1, 16'hCFC + 16'(ln), sz[1:0], wd);
              chk("R8 write request iff present", {31'b0, s_req}, {31'b0, pres});
              chk("R7 write gives no response", {31'b0, s_rv}, 0);
              if (pres) begin
                chk("R6 write flag", {31'b0, s_we}, 1);
                chk("R4 write offset", {24'b0, s_off}, {24'b0, dw, 2'(ln)});
                chk("R6 write lanes", s_wd, (wd & m) << (8 * ln));
              end
            end
          end
        end
      end
    end

    io_op(1, 16'hCF8, 2, 32'h8000_0004);
    io_op(0, 16'hCFF, 1, 0);
    chk("R9 word crossing no request", {31'b0, s_req}, 0);
    chk("R9 word crossing no response", {31'b0, s_rv}, 0);
    io_op(1, 16'hCFD, 2, 32'hFFFF_FFFF);
    chk("R9 dword misaligned no request", {31'b0, s_req}, 0);
    io_op(0, 16'hCFC, 3, 0);
    chk("R9 size 3 no response", {31'b0, s_rv}, 0);
    io_op(0, 16'h0080, 2, 0);
    chk("R10 foreign port no response", {31'b0, s_rv}, 0);
    io_op(1, 16'hCF4, 2, 32'h0);
    io_op(0, 16'hCF8, 2, 0);
    chk("R10 foreign write leaves address", s_rd, 32'h8000_0004);
    io_op(0, 16'hD00, 0, 0);
    chk("R10 next port no request", {31'b0, s_req}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule